// File: doc/BRIEF.md
# One-Position Shifter with Serial Fill

This block moves an n-bit operand by exactly one bit position toward the high end or toward the low end, in a single combinational pass with no clock and no reset. Whichever end a shift vacates is loaded from a dedicated serial input, one for each direction. This lets several blocks be chained into a wider shift, or lets a bit be fed in from outside. The bit that falls off each end is always visible on its own serial output, so a neighbour can take it as its fill.

A 2-bit select is shared by every per-bit multiplexer. Besides the two shift codes, it offers a pass-through code and a clear code, so the block can sit in a datapath as the operand path with no extra bypass logic. The operand width is a parameter with a default of 8.

Top module: `shifter1_fill`

## Requirements
- R1: With `sel_i` = 2'b00 (shift toward bit 0), `result_o[i]` equals `opnd_i[i+1]` for every i below W-1.
- R2: With `sel_i` = 2'b00, `result_o[W-1]` equals `fill_msb_i`.
- R3: With `sel_i` = 2'b10 (shift toward bit W-1), `result_o[i]` equals `opnd_i[i-1]` for every i above 0.
- R4: With `sel_i` = 2'b10, `result_o[0]` equals `fill_lsb_i`.
- R5: With `sel_i` = 2'b01, `result_o` equals `opnd_i` unchanged.
- R6: With `sel_i` = 2'b11, `result_o` is all zeros, whatever the operand and both fill inputs are.
- R7: `spill_lo_o` always equals `opnd_i[0]`, for every select value.
- R8: `spill_hi_o` always equals `opnd_i[W-1]`, for every select value.
- R9: `fill_lsb_i` has no effect on `result_o` when `sel_i` is 2'b00 or 2'b01, and `fill_msb_i` has no effect on `result_o` when `sel_i` is 2'b10 or 2'b01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | W | Operand to be shifted |
| sel_i | input | 2 | Function select: 00 shift down, 01 pass, 10 shift up, 11 clear |
| fill_msb_i | input | 1 | Serial bit loaded into the top position on a downward shift |
| fill_lsb_i | input | 1 | Serial bit loaded into the bottom position on an upward shift |
| result_o | output | W | Shifted, passed or cleared operand |
| spill_lo_o | output | 1 | Bit leaving the bottom end (operand bit 0) |
| spill_hi_o | output | 1 | Bit leaving the top end (operand bit W-1) |

## Verification
The assertions assume that the inputs carry known 0/1 values whenever they are evaluated. Each check is guarded so that it is skipped while the operand, the select or a fill bit is still unknown. The bench therefore drives every input to a defined value before its first sample and never leaves an input floating. Every select code, including the clear code, is a legal input, so the stimulus sweeps all four codes over the full operand range with fill values that vary independently.

// File: rtl/shifter1_pkg.sv
package shifter1_pkg;

  typedef enum logic [1:0] {
    SH_DOWN  = 2'b00,
    SH_PASS  = 2'b01,
    SH_UP    = 2'b10,
    SH_CLEAR = 2'b11
  } shift_sel_e;

endpackage

// File: rtl/shifter1_stage.sv
module shifter1_stage
  import shifter1_pkg::*;
(
  input  shift_sel_e sel,
  input  logic       from_hi,
  input  logic       own,
  input  logic       from_lo,
  output logic       y
);

  always_comb begin
    unique case (sel)
      SH_DOWN:  y = from_hi;
      SH_PASS:  y = own;
      SH_UP:    y = from_lo;
      default:  y = 1'b0;
    endcase
  end

endmodule

// File: rtl/shifter1_fill.sv
module shifter1_fill
  import shifter1_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opnd_i,
  input  logic [1:0]   sel_i,
  input  logic         fill_msb_i,
  input  logic         fill_lsb_i,
  output logic [W-1:0] result_o,
  output logic         spill_lo_o,
  output logic         spill_hi_o
);

  localparam int TOP = W - 1;

  shift_sel_e sel_e;
  // Operand widened by one bit at each end so every stage sees two neighbours.
  logic [W+1:0] ext;

  assign sel_e = shift_sel_e'(sel_i);
  assign ext   = {fill_msb_i, opnd_i, fill_lsb_i};

  for (genvar i = 0; i < W; i++) begin : g_stage
    shifter1_stage u_stage (
      .sel     (sel_e),
      .from_hi (ext[i+2]),
      .own     (ext[i+1]),
      .from_lo (ext[i]),
      .y       (result_o[i])
    );
  end

  assign spill_lo_o = opnd_i[0];
  assign spill_hi_o = opnd_i[TOP];

endmodule

// File: rtl/shifter1_fill_chk.sv
module shifter1_fill_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] opnd_i,
  input logic [1:0]   sel_i,
  input logic         fill_msb_i,
  input logic         fill_lsb_i,
  input logic [W-1:0] result_o,
  input logic         spill_lo_o,
  input logic         spill_hi_o
);

  logic known;
  assign known = !$isunknown({opnd_i, sel_i, fill_msb_i, fill_lsb_i});

  always_comb begin
    if (known) begin
      if (sel_i == 2'b00) begin
        assert_down_body_R1: assert (result_o[W-2:0] == opnd_i[W-1:1]);
        assert_down_fill_R2: assert (result_o[W-1] == fill_msb_i);
      end
      if (sel_i == 2'b10) begin
        assert_up_body_R3: assert (result_o[W-1:1] == opnd_i[W-2:0]);
        assert_up_fill_R4: assert (result_o[0] == fill_lsb_i);
      end
      if (sel_i == 2'b01) begin
        assert_pass_R5: assert (result_o == opnd_i);
      end
      if (sel_i == 2'b11) begin
        assert_clear_R6: assert ($countones(result_o) == 0);
      end
      assert_spill_lo_R7: assert (spill_lo_o == opnd_i[0]);
      assert_spill_hi_R8: assert (spill_hi_o == opnd_i[W-1]);
    end
  end

endmodule

bind shifter1_fill shifter1_fill_chk #(.W(W)) u_chk (
  .opnd_i     (opnd_i),
  .sel_i      (sel_i),
  .fill_msb_i (fill_msb_i),
  .fill_lsb_i (fill_lsb_i),
  .result_o   (result_o),
  .spill_lo_o (spill_lo_o),
  .spill_hi_o (spill_hi_o)
);

// File: tb/tb_shifter1_fill.sv
module tb_shifter1_fill;

  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int NVEC = 12;
  localparam int WATCHDOG_CYC = 20000;

  typedef struct packed {
    logic [7:0] op;
    logic [1:0] sel;
    logic       fm;
    logic       fl;
    logic [7:0] exp;
    logic       lo;
    logic       hi;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{8'hA5, 2'b00, 1'b1, 1'b0, 8'hD2, 1'b1, 1'b1},
    '{8'hA5, 2'b00, 1'b0, 1'b1, 8'h52, 1'b1, 1'b1},
    '{8'hA5, 2'b10, 1'b0, 1'b1, 8'h4B, 1'b1, 1'b1},
    '{8'hA5, 2'b10, 1'b1, 1'b0, 8'h4A, 1'b1, 1'b1},
    '{8'h3C, 2'b01, 1'b1, 1'b1, 8'h3C, 1'b0, 1'b0},
    '{8'hFF, 2'b11, 1'b1, 1'b1, 8'h00, 1'b1, 1'b1},
    '{8'h81, 2'b00, 1'b0, 1'b0, 8'h40, 1'b1, 1'b1},
    '{8'h81, 2'b10, 1'b0, 1'b0, 8'h02, 1'b1, 1'b1},
    '{8'h00, 2'b00, 1'b1, 1'b1, 8'h80, 1'b0, 1'b0},
    '{8'h00, 2'b10, 1'b1, 1'b1, 8'h01, 1'b0, 1'b0},
    '{8'h7E, 2'b00, 1'b0, 1'b1, 8'h3F, 1'b0, 1'b0},
    '{8'h7E, 2'b10, 1'b1, 1'b0, 8'hFC, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic [W-1:0] opnd;
  logic [1:0]   sel;
  logic         fm, fl;
  logic [W-1:0] res;
  logic         slo, shi;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shifter1_fill #(.W(W)) dut (
    .opnd_i     (opnd),
    .sel_i      (sel),
    .fill_msb_i (fm),
    .fill_lsb_i (fl),
    .result_o   (res),
    .spill_lo_o (slo),
    .spill_hi_o (shi)
  );

  function automatic logic [W-1:0] model(input logic [W-1:0] o, input logic [1:0] s,
                                         input logic m, input logic l);
    case (s)
      2'b00:   return {m, o[W-1:1]};
      2'b01:   return o;
      2'b10:   return {o[W-2:0], l};
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] s);
    case (s)
      2'b00:   return "R1/R2";
      2'b01:   return "R5";
      2'b10:   return "R3/R4";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (op=%h sel=%b fm=%b fl=%b)",
               req, act, exp, opnd, sel, fm, fl);
    end
  endtask

  task automatic apply(input logic [W-1:0] o, input logic [1:0] s,
                       input logic m, input logic l);
    @(negedge clk);
    opnd = o; sel = s; fm = m; fl = l;
    #1;
  endtask

  initial begin
    opnd = '0; sel = 2'b01; fm = 1'b0; fl = 1'b0;
    #1;
    // Initial state with all-zero operand in pass mode
    check("R5", res, '0);
    check("R7", {7'd0, slo}, 8'd0);
    check("R8", {7'd0, shi}, 8'd0);

    // Vector table
    for (int k = 0; k < NVEC; k++) begin
      apply(VECS[k].op, VECS[k].sel, VECS[k].fm, VECS[k].fl);
      check(req_of(VECS[k].sel), res, VECS[k].exp);
      check("R7", {7'd0, slo}, {7'd0, VECS[k].lo});
      check("R8", {7'd0, shi}, {7'd0, VECS[k].hi});
    end

    // Full sweep of operand and select, fills varied
    for (int o = 0; o < 256; o++) begin
      for (int s = 0; s < 4; s++) begin
        apply(o[7:0], s[1:0], o[3] ^ s[0], o[6] ^ s[1]);
        check(req_of(s[1:0]), res, model(o[7:0], s[1:0], o[3] ^ s[0], o[6] ^ s[1]));
        check("R7", {7'd0, slo}, {7'd0, o[0]});
        check("R8", {7'd0, shi}, {7'd0, o[7]});
      end
    end

    // R2 and R4: fill bits land in the vacated ends
    apply(8'h00, 2'b00, 1'b1, 1'b0);
    check("R2", res, 8'h80);
    apply(8'h00, 2'b10, 1'b0, 1'b1);
    check("R4", res, 8'h01);

    // R9: opposite-direction fill and fills in pass mode have no effect
    apply(8'h96, 2'b00, 1'b0, 1'b0);
    check("R9", res, 8'h4B);
    apply(8'h96, 2'b00, 1'b0, 1'b1);
    check("R9", res, 8'h4B);
    apply(8'h96, 2'b10, 1'b0, 1'b0);
    check("R9", res, 8'h2C);
    apply(8'h96, 2'b10, 1'b1, 1'b0);
    check("R9", res, 8'h2C);
    apply(8'h96, 2'b01, 1'b1, 1'b1);
    check("R9", res, 8'h96);

    // R6: clear ignores both fills and operand
    apply(8'hFF, 2'b11, 1'b0, 1'b0);
    check("R6", res, 8'h00);
    apply(8'h55, 2'b11, 1'b1, 1'b0);
    check("R6", res, 8'h00);
    check("R7", {7'd0, slo}, 8'd1);
    check("R8", {7'd0, shi}, 8'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule